// File: doc/BRIEF.md
# Three-Level Translation Table Walker

This block searches the translation tables in memory when the translation cache misses, or when a probe command asks for a search. It receives the logical page number, a privilege flag that selects the user or the supervisor root pointer, a read/write flag and a page-size select (4 KB or 8 KB). It then walks a three-level tree: a root table, a pointer table and a page table. Each level is indexed by its own field of the logical address. A page-table entry can also be an indirect pointer, and in that case one more read fetches the real page descriptor.

Every address taken from a descriptor is physical and goes onto the memory port without change. On a normal search the walker sets the used bit of the page descriptor, and on a write it also sets the modified bit. It writes the descriptor back only when one of these bits actually changes. The finished descriptor is offered on a fill output for the translation cache. A probe search also loads the cache, but it leaves the history bits alone and records its outcome in a status register.

Top module: `tw_walker`

## Requirements
- R1: `start`, sampled while `busy` is low, begins a search. The first read goes to the root pointer (`super_root` when `req_super` is 1, else `user_root`) with bits [8:0] cleared, ORed with logical address bits [31:25] shifted left by 2. `req_vpn` carries logical address bits [31:12].
- R2: The second read goes to the root-table entry with bits [8:0] cleared, ORed with logical address bits [24:18] shifted left by 2.
- R3: The third read goes to the pointer-table entry with its low bits cleared, ORed with an index shifted left by 2. With `page8k`=0 the low 8 bits are cleared and the index is logical address bits [17:12]. With `page8k`=1 the low 7 bits are cleared and the index is bits [17:13].
- R4: Descriptor bits [1:0] are a type field: 00 invalid, 10 indirect, 01 or 11 resident. An invalid type at any level ends the search with `fault` high together with `done`, `fill_valid` low, and no memory write.
- R5: A type of 10 in a page-table entry causes exactly one further read, at the entry with bits [1:0] cleared. If that word's type is not resident (01/11), the search faults.
- R6: On a non-probe search, the page descriptor returned has bit 3 (used) set, and also bit 4 (modified) set when `req_write` is 1. A single write of that value goes to the address the descriptor was read from, and only when it differs from the value read.
- R7: A probe search (`req_probe`=1) returns the descriptor unchanged and writes nothing.
- R8: A probe updates `probe_stat` = {fault, indirect, level[1:0]} one cycle after `done`. The level is 1, 2 or 3 for the root, pointer or page level at which the search ended. Non-probe searches leave `probe_stat` unchanged.
- R9: `done` is a one-cycle pulse. `fill_valid` rises with it when there is no fault, with the final descriptor on `fill_desc`.
- R10: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until `mem_ack`. After reset the block is idle with `mem_req`, `done` and `probe_stat` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (taken when idle) |
| req_vpn | input | 20 | Logical address bits [31:12] |
| req_super | input | 1 | Supervisor access: selects the root pointer |
| req_write | input | 1 | Access is a write (sets modified bit) |
| req_probe | input | 1 | Search is a probe command |
| page8k | input | 1 | 1 = 8 KB pages, 0 = 4 KB pages |
| user_root | input | 32 | User root table pointer |
| super_root | input | 32 | Supervisor root table pointer |
| busy | output | 1 | Search in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Physical byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Memory access complete |
| done | output | 1 | Search finished (one-cycle pulse) |
| fault | output | 1 | Search ended on an invalid descriptor |
| fill_valid | output | 1 | Load fill_desc into the translation cache |
| fill_desc | output | 32 | Resulting page descriptor |
| probe_stat | output | 4 | Probe status {fault, indirect, level[1:0]} |

## Verification
The hardest cases to reach are the ones that end deep in the tree. These are a fault on the word fetched through an indirect pointer, and a write-back that depends on which history bits were already set. Neither happens unless the three earlier levels resolve correctly. The bench therefore rebuilds a complete table set in its memory model before every search, for each combination of privilege, page size, indirection, access direction, preset used/modified bits and probe. It then corrupts one chosen level on purpose to steer the walk into each fault point. The memory latency is varied between searches so that the hold-until-acknowledge behaviour is exercised.

// File: rtl/tw_pkg.sv
package tw_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2,
      ST_DONE  = 2'd3
   } tw_state_e;

   localparam logic [1:0] DT_INVALID  = 2'b00;
   localparam logic [1:0] DT_INDIRECT = 2'b10;

   typedef struct packed {
      logic       fault;
      logic       indirect;
      logic [1:0] level;
   } tw_stat_t;

   function automatic logic dt_valid(input logic [1:0] t);
      return t != DT_INVALID;
   endfunction

   function automatic logic dt_resident(input logic [1:0] t);
      return t[0];
   endfunction
endpackage

// File: rtl/tw_addr_gen.sv
module tw_addr_gen #(
   parameter int AW    = 32,
   parameter int PG_SH = 12,
   parameter int L1_W  = 7,
   parameter int L2_W  = 7,
   parameter int L3_W  = 6
) (
   input  logic [AW-PG_SH-1:0] vpn,
   input  logic                page8k,
   input  logic [1:0]          step,
   input  logic [AW-1:0]       base,
   output logic [AW-1:0]       addr
);
   localparam int VW     = AW - PG_SH;
   localparam int L2_TOP = VW - L1_W;
   localparam int L3_TOP = L2_TOP - L2_W;

   generate
      if (L1_W + L2_W + L3_W != VW) begin : g_bad_split
         $error("tw_addr_gen: index fields do not cover the page number");
      end
      if (L3_W < 2) begin : g_bad_l3
         $error("tw_addr_gen: page index too narrow for the large page");
      end
   endgenerate

   logic [AW-1:0] idx;
   int unsigned   al;

   always_comb begin
      idx = '0;
      al  = 2;
      case (step)
         2'd0: begin
            idx = AW'(vpn[VW-1 -: L1_W]);
            al  = L1_W + 2;
         end
         2'd1: begin
            idx = AW'(vpn[L2_TOP-1 -: L2_W]);
            al  = L2_W + 2;
         end
         2'd2: begin
            if (page8k) begin
               idx = AW'(vpn[L3_TOP-1 -: L3_W-1]);
               al  = L3_W + 1;
            end else begin
               idx = AW'(vpn[L3_TOP-1 -: L3_W]);
               al  = L3_W + 2;
            end
         end
         default: begin
            idx = '0;
            al  = 2;
         end
      endcase
      addr = (base & ~((AW'(1) << al) - AW'(1))) | (idx << 2);
   end
endmodule

// File: rtl/tw_seq.sv
module tw_seq import tw_pkg::*; #(
   parameter int AW    = 32,
   parameter int VW    = 20,
   parameter int U_BIT = 3,
   parameter int M_BIT = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [VW-1:0]  req_vpn,
   input  logic           req_super,
   input  logic           req_write,
   input  logic           req_probe,
   input  logic           page8k_in,
   input  logic [AW-1:0]  user_root,
   input  logic [AW-1:0]  super_root,
   input  logic           mem_ack,
   input  logic [AW-1:0]  mem_rdata,
   input  logic [AW-1:0]  rd_addr,
   output tw_state_e      state,
   output logic [1:0]     step,
   output logic [VW-1:0]  vpn,
   output logic           page8k,
   output logic [AW-1:0]  base,
   output logic [AW-1:0]  pd,
   output logic [AW-1:0]  pd_addr,
   output logic           fault_q,
   output logic           ind_q,
   output logic           probe_q
);
   logic          wr_q;
   logic [1:0]    dtype;
   logic [AW-1:0] upd;
   logic          need_wb;

   assign dtype = mem_rdata[1:0];

   always_comb begin
      upd = mem_rdata;
      if (!probe_q) begin
         upd[U_BIT] = 1'b1;
         if (wr_q) upd[M_BIT] = 1'b1;
      end
      need_wb = (upd != mem_rdata);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         step    <= '0;
         vpn     <= '0;
         page8k  <= 1'b0;
         base    <= '0;
         pd      <= '0;
         pd_addr <= '0;
         fault_q <= 1'b0;
         ind_q   <= 1'b0;
         probe_q <= 1'b0;
         wr_q    <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               vpn     <= req_vpn;
               page8k  <= page8k_in;
               wr_q    <= req_write;
               probe_q <= req_probe;
               base    <= req_super ? super_root : user_root;
               step    <= 2'd0;
               fault_q <= 1'b0;
               ind_q   <= 1'b0;
               state   <= ST_READ;
            end
            ST_READ: if (mem_ack) begin
               if (!dt_valid(dtype) || (step == 2'd3 && !dt_resident(dtype))) begin
                  fault_q <= 1'b1;
                  state   <= ST_DONE;
               end else if (step == 2'd2 && dtype == DT_INDIRECT) begin
                  base  <= mem_rdata;
                  step  <= 2'd3;
                  ind_q <= 1'b1;
               end else if (step >= 2'd2) begin
                  pd      <= upd;
                  pd_addr <= rd_addr;
                  state   <= need_wb ? ST_WRITE : ST_DONE;
               end else begin
                  base <= mem_rdata;
                  step <= step + 2'd1;
               end
            end
            ST_WRITE: if (mem_ack) state <= ST_DONE;
            default:  state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/tw_stat_reg.sv
module tw_stat_reg import tw_pkg::*; (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       done,
   input  logic       probe,
   input  logic       fault,
   input  logic       ind,
   input  logic [1:0] step,
   output tw_stat_t   stat
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat <= '0;
      end else if (done && probe) begin
         stat.fault    <= fault;
         stat.indirect <= ind;
         stat.level    <= (step == 2'd3) ? 2'd3 : step + 2'd1;
      end
   end
endmodule

// File: rtl/tw_walker.sv
module tw_walker import tw_pkg::*; #(
   parameter int AW    = 32,
   parameter int PG_SH = 12,
   parameter int L1_W  = 7,
   parameter int L2_W  = 7,
   parameter int L3_W  = 6,
   parameter int U_BIT = 3,
   parameter int M_BIT = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [AW-PG_SH-1:0] req_vpn,
   input  logic                req_super,
   input  logic                req_write,
   input  logic                req_probe,
   input  logic                page8k,
   input  logic [AW-1:0]       user_root,
   input  logic [AW-1:0]       super_root,
   output logic                busy,
   output logic                mem_req,
   output logic                mem_we,
   output logic [AW-1:0]       mem_addr,
   output logic [AW-1:0]       mem_wdata,
   input  logic [AW-1:0]       mem_rdata,
   input  logic                mem_ack,
   output logic                done,
   output logic                fault,
   output logic                fill_valid,
   output logic [AW-1:0]       fill_desc,
   output logic [3:0]          probe_stat
);
   localparam int VW = AW - PG_SH;

   generate
      if (U_BIT < 2 || M_BIT < 2 || U_BIT >= AW || M_BIT >= AW || U_BIT == M_BIT) begin : g_bad_hist
         $error("tw_walker: history bit positions collide with the type field or each other");
      end
   endgenerate

   tw_state_e     state;
   logic [1:0]    step;
   logic [VW-1:0] vpn_q;
   logic          p8_q;
   logic [AW-1:0] base, pd, pd_addr, rd_addr;
   logic          fault_q, ind_q, probe_q;
   tw_stat_t      stat;

   tw_seq #(.AW(AW), .VW(VW), .U_BIT(U_BIT), .M_BIT(M_BIT)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .req_vpn(req_vpn),
      .req_super(req_super), .req_write(req_write), .req_probe(req_probe),
      .page8k_in(page8k), .user_root(user_root), .super_root(super_root),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .rd_addr(rd_addr),
      .state(state), .step(step), .vpn(vpn_q), .page8k(p8_q), .base(base),
      .pd(pd), .pd_addr(pd_addr), .fault_q(fault_q), .ind_q(ind_q), .probe_q(probe_q)
   );

   tw_addr_gen #(.AW(AW), .PG_SH(PG_SH), .L1_W(L1_W), .L2_W(L2_W), .L3_W(L3_W)) u_addr (
      .vpn(vpn_q), .page8k(p8_q), .step(step), .base(base), .addr(rd_addr)
   );

   tw_stat_reg u_stat (
      .clk(clk), .rst_n(rst_n), .done(done), .probe(probe_q),
      .fault(fault_q), .ind(ind_q), .step(step), .stat(stat)
   );

   assign busy       = (state != ST_IDLE);
   assign mem_req    = (state == ST_READ) || (state == ST_WRITE);
   assign mem_we     = (state == ST_WRITE);
   assign mem_addr   = (state == ST_WRITE) ? pd_addr : rd_addr;
   assign mem_wdata  = pd;
   assign done       = (state == ST_DONE);
   assign fault      = done && fault_q;
   assign fill_valid = done && !fault_q;
   assign fill_desc  = pd;
   assign probe_stat = stat;
endmodule

// File: rtl/tw_walker_chk.sv
module tw_walker_chk #(
   parameter int AW    = 32,
   parameter int PG_SH = 12,
   parameter int L1_W  = 7,
   parameter int U_BIT = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic                busy,
   input logic [AW-PG_SH-1:0] req_vpn,
   input logic                req_super,
   input logic [AW-1:0]       user_root,
   input logic [AW-1:0]       super_root,
   input logic                mem_req,
   input logic                mem_we,
   input logic                mem_ack,
   input logic [AW-1:0]       mem_addr,
   input logic [AW-1:0]       mem_wdata,
   input logic                done
);
   localparam int VW = AW - PG_SH;

   // R1: first access is a read of the selected root table entry
   a_r1_root_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (mem_req && !mem_we
         && mem_addr[AW-1:L1_W+2] == ($past(req_super) ? $past(super_root[AW-1:L1_W+2])
                                                        : $past(user_root[AW-1:L1_W+2]))
         && mem_addr[L1_W+1:2] == $past(req_vpn[VW-1 -: L1_W])
         && mem_addr[1:0] == 2'b00));

   // R10: request fields held until acknowledged
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

   // R6: any write-back carries the used bit
   a_r6_wb_used: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> mem_wdata[U_BIT]);

   // R9: completion is a single-cycle pulse
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10: no memory traffic while idle
   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);
endmodule

bind tw_walker tw_walker_chk #(.AW(AW), .PG_SH(PG_SH), .L1_W(L1_W), .U_BIT(U_BIT)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .req_vpn(req_vpn),
   .req_super(req_super), .user_root(user_root), .super_root(super_root),
   .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
   .mem_wdata(mem_wdata), .done(done)
);

// File: tb/tw_walker_test.sv
module tw_walker_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        start, req_super, req_write, req_probe, page8k;
   logic [19:0] req_vpn;
   logic [31:0] user_root, super_root;
   logic        busy, mem_req, mem_we, mem_ack, done, fault, fill_valid;
   logic [31:0] mem_addr, mem_wdata, mem_rdata, fill_desc;
   logic [3:0]  probe_stat;

   always #5 clk = ~clk;

   tw_walker uut (
      .clk(clk), .rst_n(rst_n), .start(start), .req_vpn(req_vpn),
      .req_super(req_super), .req_write(req_write), .req_probe(req_probe),
      .page8k(page8k), .user_root(user_root), .super_root(super_root),
      .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
      .done(done), .fault(fault), .fill_valid(fill_valid),
      .fill_desc(fill_desc), .probe_stat(probe_stat)
   );

   // memory model: 4 KB, variable latency
   logic [31:0] mem [0:1023];
   int          lat, cnt, wr_count, rd_count;
   logic        ack_q;
   logic [31:0] rdata_q;
   assign mem_ack   = ack_q;
   assign mem_rdata = rdata_q;

   always @(posedge clk) begin
      if (!rst_n) begin
         ack_q <= 1'b0;
         cnt   <= 0;
      end else if (ack_q) begin
         ack_q <= 1'b0;
         cnt   <= 0;
      end else if (mem_req) begin
         if (cnt >= lat) begin
            ack_q   <= 1'b1;
            rdata_q <= mem[mem_addr[11:2]];
            if (mem_we) begin
               mem[mem_addr[11:2]] <= mem_wdata;
               wr_count <= wr_count + 1;
            end else begin
               rd_count <= rd_count + 1;
            end
         end else begin
            cnt <= cnt + 1;
         end
      end
   end

   int n_chk = 0, n_bad = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
   end

   // fields of the current search
   logic [31:0] la, pdv, pda, root_b;
   int          i1, i2, i3, pe;

   task automatic clear_mem();
      for (int k = 0; k < 1024; k++) mem[k] = 32'h0;
   endtask

   task automatic build(input logic sup, input logic p8, input logic ind);
      clear_mem();
      root_b = sup ? 32'h200 : 32'h000;
      i1 = int'(la[31:25]);
      i2 = int'(la[24:18]);
      i3 = p8 ? int'(la[17:13]) : int'(la[17:12]);
      mem[(root_b + i1 * 4) >> 2] = 32'h0000_05F1;
      mem[(32'h400 + i2 * 4) >> 2] = p8 ? 32'h0000_067D : 32'h0000_06FD;
      pe = 32'h600 + i3 * 4;
      if (ind) begin
         mem[pe >> 2] = 32'h0000_07A6;
         mem[32'h7A4 >> 2] = pdv;
         pda = 32'h7A4;
      end else begin
         mem[pe >> 2] = pdv;
         pda = pe;
      end
   endtask

   task automatic run(input logic sup, input logic p8, input logic wr, input logic prb);
      @(negedge clk);
      req_vpn   = la[31:12];
      req_super = sup;
      req_write = wr;
      req_probe = prb;
      page8k    = p8;
      start     = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c < 200; c++) begin
         if (done) break;
         @(negedge clk);
      end
   endtask

   initial begin
      logic [3:0]  st_before, st_exp;
      logic [31:0] exp_desc;
      logic        wb;
      int          w0, r0, lvl;
      rst_n = 1'b0; start = 1'b0; req_vpn = '0; req_super = 0; req_write = 0;
      req_probe = 0; page8k = 0; lat = 0; wr_count = 0; rd_count = 0;
      user_root  = 32'h0000_01AB;
      super_root = 32'h0000_03F3;
      clear_mem();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 reset busy", 32'(busy), 0);
      chk("R10 reset mem_req", 32'(mem_req), 0);
      chk("R10 reset done", 32'(done), 0);
      chk("R10 reset probe_stat", 32'(probe_stat), 0);

      // resolving searches over all option combinations
      for (int i = 0; i < 128; i++) begin
         logic sup, p8, ind, wr, pu, pm, prb;
         sup = i[0]; p8 = i[1]; ind = i[2]; wr = i[3]; pu = i[4]; pm = i[5]; prb = i[6];
         lat = i % 3;
         la  = $urandom;
         pdv = ($urandom & ~32'h1B) | (la[5] ? 32'h3 : 32'h1) | (32'(pu) << 3) | (32'(pm) << 4);
         build(sup, p8, ind);
         st_before = probe_stat;
         w0 = wr_count; r0 = rd_count;
         run(sup, p8, wr, prb);
         exp_desc = prb ? pdv : (pdv | 32'h8 | (wr ? 32'h10 : 32'h0));
         wb = !prb && (!pu || (wr && !pm));
         chk("R9 done seen", 32'(done), 1);
         chk("R4 no fault", 32'(fault), 0);
         chk("R9 fill_valid", 32'(fill_valid), 1);
         chk(prb ? "R7 probe desc" : "R6 history desc", fill_desc, exp_desc);
         chk("R6 memory descriptor", mem[pda >> 2], wb ? exp_desc : pdv);
         chk(prb ? "R7 no write" : "R6 write count", 32'(wr_count - w0), wb ? 1 : 0);
         chk("R5 R1 R2 R3 read count", 32'(rd_count - r0), ind ? 4 : 3);
         @(negedge clk);
         st_exp = prb ? {1'b0, ind, 2'd3} : st_before;
         chk("R8 probe status", 32'(probe_stat), 32'(st_exp));
      end

      // fault at each point of the walk
      for (int j = 0; j < 40; j++) begin
         logic sup, p8, prb, ind;
         int   f;
         f = 1 + j / 8; sup = j[0]; p8 = j[1]; prb = j[2];
         ind = (f >= 4);
         lat = j % 2;
         la  = $urandom;
         pdv = ($urandom & ~32'h1B) | 32'h1;
         build(sup, p8, ind);
         case (f)
            1: mem[(root_b + i1 * 4) >> 2] = 32'h0000_05F0;
            2: mem[(32'h400 + i2 * 4) >> 2] = 32'h0000_067C;
            3: mem[pe >> 2] = pdv & ~32'h3;
            4: mem[32'h7A4 >> 2] = 32'h0000_07A6;
            default: mem[32'h7A4 >> 2] = pdv & ~32'h3;
         endcase
         lvl = (f >= 3) ? 3 : f;
         w0 = wr_count;
         st_before = probe_stat;
         run(sup, p8, 1'b1, prb);
         chk("R4 fault flag", 32'(fault), 1);
         chk("R4 no fill", 32'(fill_valid), 0);
         chk("R4 no write on fault", 32'(wr_count - w0), 0);
         @(negedge clk);
         st_exp = prb ? {1'b1, ind, 2'(lvl)} : st_before;
         chk(f >= 4 ? "R5 R8 indirect fault status" : "R8 fault status", 32'(probe_stat), 32'(st_exp));
      end
      summary();
   end
endmodule